// File: doc/BRIEF.md
# Page-Splitting Serial Flash Program Sequencer

This block takes one write request (a 24-bit start address, a byte count and a stream of data bytes) and turns it into page-program commands for a serial NOR flash on a four-wire SPI bus. Each command stays inside one 256-byte page. The first command covers only what is left of the starting page. Each later command covers a full page, except the last, which covers what remains. The block drives the SPI bus itself through an internal byte shifter.

Before each chunk the block reads the flash status register until the write-in-progress flag is clear. It then sets the write-enable latch in a frame of its own, and then sends the program command. The program command is the opcode, three address bytes and the chunk data, all under one chip-select assertion. When the request is finished the block gives a one-cycle completion pulse with the number of data bytes sent. A request of zero length completes at once. A request that would run past the end of the device is refused without any bus activity.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `dat_ready`, `busy` and `done` are all 0.
- R2: A request with length 0 gives `done`=1 in the cycle after it is accepted, with `done_count`=0 and `done_reject`=0, and causes no chip-select activity.
- R3: A request whose start address plus length is greater than `DEV_BYTES` gives `done`=1 in the next cycle, with `done_reject`=1, `done_count`=0 and no bus activity. A request that ends exactly at `DEV_BYTES` is carried out.
- R4: Chunk sizes follow this rule. If (address mod 256) + length is at most 256, the request goes out as a single program command. Otherwise the first chunk is 256 − (address mod 256) bytes, and each later chunk is the smaller of 256 and the bytes still remaining.
- R5: A program frame is byte 0x02, then three address bytes with bits 23:16 first, then the chunk data. The frame's address is the start address plus the number of data bytes already sent.
- R6: Each program frame is preceded by status frames and then a write-enable frame. A status frame is two bytes, 0x05 and then a dummy 0x00. Status frames repeat while bit 0 of the returned second byte is 1. The write-enable frame is the single byte 0x06.
- R7: `done` is high for exactly one cycle when the last data byte has been sent. In that cycle `done_count` equals the request length and `done_reject` is 0.
- R8: `dat_ready` is high only while a chunk's data is being sent with chip select low. Bytes go out in the order they are accepted. When `dat_valid` is low, chip select stays low and the frame waits.
- R9: The bus runs in SPI mode 0. `spi_sclk` idles low and stays high for one cycle per bit. `spi_sclk` is high only while `spi_cs_n` is low. `spi_mosi` does not change while `spi_sclk` is high. Bits go out MSB first, and every frame holds whole bytes.
- R10: While `busy` is 1, `wr_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Request strobe, taken only while idle |
| wr_addr | input | 24 | Start byte address |
| wr_len | input | LEN_W | Number of bytes to write |
| dat_valid | input | 1 | Data byte available |
| dat_data | input | 8 | Data byte |
| dat_ready | output | 1 | Data byte taken on this edge when valid |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_reject | output | 1 | Request was refused (valid with done) |
| done_count | output | LEN_W | Data bytes sent (valid with done) |

## Verification
The bench stresses page arithmetic at its edges:
- a write that exactly fills the rest of a page, which a design with an off-by-one split would break into a second one-byte command;
- a write one byte longer than that;
- a write starting on the last byte of a page and spanning several pages, where a wrong first-chunk size shifts every later address;
- a write that ends exactly at the device limit next to one that overruns it by a byte, so an inclusive or exclusive mistake in the range check shows up.

A slave model returns "busy" for a configurable number of status polls. A design that skips the poll, or polls only once, produces a frame sequence that no longer matches.

Data-valid gaps and a stray start strobe during a transfer catch designs that drop chip select mid-frame or restart.

// File: rtl/flash_pw_pkg.sv
package flash_pw_pkg;

  localparam int HDR_ADDR_W = 24;

  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_DUMMY = 8'h00;

  localparam logic [7:0] WIP_MASK = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL_OP,
    ST_POLL_RD,
    ST_WEN,
    ST_HDR,
    ST_DATA,
    ST_GAP
  } seq_state_t;

endpackage

// File: rtl/fpw_byte_shifter.sv
// Mode-0 byte serializer: one low and one high clock phase per bit, MSB first.
module fpw_byte_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BITS-1:0] tx,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic            sclk,
  output logic            mosi,
  output logic [BITS-1:0] rx
);

  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;

  logic            active;
  logic [BITS-1:0] shreg;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      shreg  <= '0;
      cnt    <= '0;
      sclk   <= 1'b0;
      done   <= 1'b0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          shreg  <= tx;
          cnt    <= '0;
          sclk   <= 1'b0;
        end
      end else if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk  <= 1'b0;
        rx    <= {rx[BITS-2:0], miso};
        shreg <= {shreg[BITS-2:0], 1'b0};
        if (cnt == CW'(BITS - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy = active;
  assign mosi = shreg[BITS-1];

endmodule

// File: rtl/fpw_chunk_calc.sv
// Size of the next program chunk: the room left in the page or the remainder.
module fpw_chunk_calc #(
  parameter int PAGE_BYTES = 256,
  parameter int LEN_W      = 16,
  localparam int POFF_W    = $clog2(PAGE_BYTES),
  localparam int CL_W      = POFF_W + 1
) (
  input  logic [POFF_W-1:0] page_off,
  input  logic [LEN_W-1:0]  remaining,
  output logic [CL_W-1:0]   chunk_len
);

  localparam int CMP_W = (LEN_W > CL_W) ? LEN_W : CL_W;

  logic [CL_W-1:0]  room;
  logic [CMP_W-1:0] room_x;
  logic [CMP_W-1:0] rem_x;

  always_comb begin
    room   = CL_W'(PAGE_BYTES) - CL_W'(page_off);
    room_x = CMP_W'(room);
    rem_x  = CMP_W'(remaining);
    if (rem_x < room_x) chunk_len = CL_W'(remaining);
    else                chunk_len = room;
  end

endmodule

// File: rtl/fpw_tx_select.sv
// Chooses the byte to shift next and whether one is ready, from the sequencer state.
module fpw_tx_select
  import flash_pw_pkg::*;
(
  input  seq_state_t            state,
  input  logic [1:0]            hdr_idx,
  input  logic [HDR_ADDR_W-1:0] addr,
  input  logic                  dat_valid,
  input  logic [7:0]            dat_data,
  output logic                  want,
  output logic [7:0]            tx_byte
);

  always_comb begin
    want    = 1'b0;
    tx_byte = OP_DUMMY;
    unique case (state)
      ST_POLL_OP: begin want = 1'b1; tx_byte = OP_STAT; end
      ST_POLL_RD: begin want = 1'b1; tx_byte = OP_DUMMY; end
      ST_WEN:     begin want = 1'b1; tx_byte = OP_WEN; end
      ST_HDR: begin
        want = 1'b1;
        unique case (hdr_idx)
          2'd0: tx_byte = OP_PROG;
          2'd1: tx_byte = addr[23:16];
          2'd2: tx_byte = addr[15:8];
          default: tx_byte = addr[7:0];
        endcase
      end
      ST_DATA: begin want = dat_valid; tx_byte = dat_data; end
      default: begin want = 1'b0; tx_byte = OP_DUMMY; end
    endcase
  end

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import flash_pw_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int LEN_W      = 16,
  parameter int DEV_BYTES  = 1 << 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_start,
  input  logic [HDR_ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]      wr_len,
  input  logic                  dat_valid,
  input  logic [7:0]            dat_data,
  output logic                  dat_ready,
  output logic                  spi_cs_n,
  output logic                  spi_sclk,
  output logic                  spi_mosi,
  input  logic                  spi_miso,
  output logic                  busy,
  output logic                  done,
  output logic                  done_reject,
  output logic [LEN_W-1:0]      done_count
);

  localparam int POFF_W = $clog2(PAGE_BYTES);
  localparam int CL_W   = POFF_W + 1;
  localparam int SUM_W  = ((HDR_ADDR_W > LEN_W) ? HDR_ADDR_W : LEN_W) + 1;

  seq_state_t            state, ret_state;
  logic [HDR_ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]      remaining;
  logic [LEN_W-1:0]      sent;
  logic [CL_W-1:0]       chunk_left;
  logic [1:0]            hdr_idx;

  logic                  sh_start, sh_busy, sh_done;
  logic [7:0]            sh_rx, tx_byte;
  logic                  want;
  logic [CL_W-1:0]       next_chunk;
  logic [SUM_W-1:0]      end_sum;

  fpw_tx_select u_txsel (
    .state     (state),
    .hdr_idx   (hdr_idx),
    .addr      (cur_addr),
    .dat_valid (dat_valid),
    .dat_data  (dat_data),
    .want      (want),
    .tx_byte   (tx_byte)
  );

  fpw_chunk_calc #(
    .PAGE_BYTES (PAGE_BYTES),
    .LEN_W      (LEN_W)
  ) u_chunk (
    .page_off  (cur_addr[POFF_W-1:0]),
    .remaining (remaining),
    .chunk_len (next_chunk)
  );

  fpw_byte_shifter #(.BITS(8)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .start (sh_start),
    .tx    (tx_byte),
    .miso  (spi_miso),
    .busy  (sh_busy),
    .done  (sh_done),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .rx    (sh_rx)
  );

  assign sh_start  = want && !sh_busy && !sh_done;
  assign dat_ready = (state == ST_DATA) && !sh_busy && !sh_done;
  assign end_sum   = SUM_W'(wr_addr) + SUM_W'(wr_len);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ret_state   <= ST_IDLE;
      cur_addr    <= '0;
      remaining   <= '0;
      sent        <= '0;
      chunk_left  <= '0;
      hdr_idx     <= '0;
      spi_cs_n    <= 1'b1;
      done        <= 1'b0;
      done_reject <= 1'b0;
      done_count  <= '0;
    end else begin
      done <= 1'b0;
      if (sh_start) spi_cs_n <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (wr_start) begin
            if (wr_len == '0) begin
              done        <= 1'b1;
              done_reject <= 1'b0;
              done_count  <= '0;
            end else if (end_sum > SUM_W'(DEV_BYTES)) begin
              done        <= 1'b1;
              done_reject <= 1'b1;
              done_count  <= '0;
            end else begin
              cur_addr  <= wr_addr;
              remaining <= wr_len;
              sent      <= '0;
              state     <= ST_POLL_OP;
            end
          end
        end

        ST_POLL_OP: if (sh_done) state <= ST_POLL_RD;

        ST_POLL_RD: begin
          if (sh_done) begin
            spi_cs_n  <= 1'b1;
            state     <= ST_GAP;
            ret_state <= ((sh_rx & WIP_MASK) != 8'h00) ? ST_POLL_OP : ST_WEN;
          end
        end

        ST_WEN: begin
          if (sh_done) begin
            spi_cs_n   <= 1'b1;
            state      <= ST_GAP;
            ret_state  <= ST_HDR;
            hdr_idx    <= '0;
            chunk_left <= next_chunk;
          end
        end

        ST_HDR: begin
          if (sh_done) begin
            hdr_idx <= hdr_idx + 2'd1;
            if (hdr_idx == 2'd3) state <= ST_DATA;
          end
        end

        ST_DATA: begin
          if (sh_done) begin
            cur_addr   <= cur_addr + 1'b1;
            remaining  <= remaining - 1'b1;
            sent       <= sent + 1'b1;
            chunk_left <= chunk_left - 1'b1;
            if (chunk_left == CL_W'(1)) begin
              spi_cs_n <= 1'b1;
              if (remaining == LEN_W'(1)) begin
                done        <= 1'b1;
                done_reject <= 1'b0;
                done_count  <= sent + 1'b1;
                state       <= ST_IDLE;
              end else begin
                state     <= ST_GAP;
                ret_state <= ST_POLL_OP;
              end
            end
          end
        end

        ST_GAP: state <= ret_state;

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpw_checker.sv
module fpw_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             spi_cs_n,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             dat_ready,
  input logic             busy,
  input logic             done,
  input logic             done_reject,
  input logic [LEN_W-1:0] done_count
);

  a_r9_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !spi_cs_n);

  a_r9_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> $stable(spi_mosi));

  a_r9_high_one_cycle: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |=> !spi_sclk);

  a_r8_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
    dat_ready |-> !spi_cs_n);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_reject_empty: assert property (@(posedge clk) disable iff (rst)
    (done && done_reject) |-> (done_count == '0));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (spi_cs_n && !dat_ready && !spi_sclk));

endmodule

bind flash_page_writer fpw_checker #(.LEN_W(LEN_W)) u_fpw_checker (
  .clk         (clk),
  .rst         (rst),
  .spi_cs_n    (spi_cs_n),
  .spi_sclk    (spi_sclk),
  .spi_mosi    (spi_mosi),
  .dat_ready   (dat_ready),
  .busy        (busy),
  .done        (done),
  .done_reject (done_reject),
  .done_count  (done_count)
);

// File: tb/flash_page_writer_bench.sv
module flash_page_writer_bench;

  localparam int LEN_W = 16;
  localparam int PAGE  = 256;
  localparam int DEV   = 1 << 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_start = 1'b0;
  logic [23:0]      wr_addr = '0;
  logic [LEN_W-1:0] wr_len = '0;
  logic             dat_valid = 1'b0;
  logic [7:0]       dat_data = '0;
  logic             dat_ready;
  logic             spi_cs_n, spi_sclk, spi_mosi;
  logic             spi_miso = 1'b0;
  logic             busy, done, done_reject;
  logic [LEN_W-1:0] done_count;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  flash_page_writer #(.PAGE_BYTES(PAGE), .LEN_W(LEN_W), .DEV_BYTES(DEV)) u_flash_page_writer (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr), .wr_len(wr_len),
    .dat_valid(dat_valid), .dat_data(dat_data), .dat_ready(dat_ready),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .busy(busy), .done(done), .done_reject(done_reject), .done_count(done_count)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- flash slave model ----------------
  logic [7:0] log_b[$];
  int         log_n[$];
  logic [7:0] frame[$];
  logic [7:0] sin;
  int         bitc = 0;
  int         busy_left = 0;
  int         busy_cfg = 0;
  logic [7:0] status;

  assign status = (busy_left > 0) ? 8'h03 : 8'h02;

  always @(negedge spi_cs_n) begin
    bitc = 0;
    frame.delete();
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      sin = {sin[6:0], spi_mosi};
      bitc++;
      if (bitc % 8 == 0) frame.push_back(sin);
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && bitc >= 8 && frame.size() > 0 && frame[0] == 8'h05)
      spi_miso = status[7 - (bitc % 8)];
  end

  always @(posedge spi_cs_n) begin
    if (frame.size() > 0) begin
      check(bitc % 8 == 0, "R9", "whole bytes in frame", bitc, 8 * (bitc / 8));
      foreach (frame[k]) log_b.push_back(frame[k]);
      log_n.push_back(frame.size());
      if (frame[0] == 8'h02) busy_left = busy_cfg;
      else if (frame[0] == 8'h05 && busy_left > 0) busy_left--;
      frame.delete();
    end
    bitc = 0;
  end

  // ---------------- per-clock bus monitor ----------------
  logic prev_mosi = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (spi_sclk) begin
        check(!spi_cs_n, "R9", "sclk high outside frame", spi_cs_n, 0);
        check(spi_mosi == prev_mosi, "R9", "mosi moved while sclk high", spi_mosi, prev_mosi);
      end
      if (dat_ready) check(!spi_cs_n, "R8", "ready outside frame", spi_cs_n, 0);
    end
    prev_mosi = spi_mosi;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  // ---------------- expectation building ----------------
  logic [7:0] exp_b[$];
  int         exp_n[$];
  int         model_busy = 0;

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 7 + seed * 13) & 8'hff);
  endfunction

  task automatic build_exp(input int addr, input int len, input int seed);
    int a = addr;
    int rem = len;
    int idx = 0;
    exp_b.delete();
    exp_n.delete();
    while (rem > 0) begin
      int c;
      for (int p = 0; p <= model_busy; p++) begin
        exp_b.push_back(8'h05); exp_b.push_back(8'h00); exp_n.push_back(2);
      end
      exp_b.push_back(8'h06); exp_n.push_back(1);
      c = PAGE - (a % PAGE);
      if (rem < c) c = rem;
      exp_b.push_back(8'h02);
      exp_b.push_back(8'((a >> 16) & 255));
      exp_b.push_back(8'((a >> 8) & 255));
      exp_b.push_back(8'(a & 255));
      for (int k = 0; k < c; k++) exp_b.push_back(pat(seed, idx + k));
      exp_n.push_back(4 + c);
      model_busy = busy_cfg;
      a += c; idx += c; rem -= c;
    end
  endtask

  task automatic compare_log();
    int pb = 0;
    check(log_n.size() == exp_n.size(), "R4", "frame count", log_n.size(), exp_n.size());
    for (int f = 0; f < exp_n.size() && f < log_n.size(); f++) begin
      logic [7:0] op = exp_b[pb];
      string tag = (op == 8'h02) ? "R4" : "R6";
      int bad = -1;
      check(log_n[f] == exp_n[f], tag, "frame length", log_n[f], exp_n[f]);
      if (log_n[f] != exp_n[f]) break;
      for (int k = 0; k < exp_n[f]; k++)
        if (bad < 0 && log_b[pb + k] != exp_b[pb + k]) bad = k;
      if (op == 8'h02)
        tag = (bad >= 0 && bad < 4) ? "R5" : "R8";
      check(bad < 0, tag, "frame byte",
            (bad >= 0) ? log_b[pb + bad] : 0, (bad >= 0) ? exp_b[pb + bad] : 0);
      pb += exp_n[f];
    end
  endtask

  // ---------------- request drivers ----------------
  task automatic quick_req(input int addr, input int len, input bit exp_rej, input string tag);
    log_b.delete(); log_n.delete();
    @(negedge clk);
    wr_start = 1'b1; wr_addr = 24'(addr); wr_len = LEN_W'(len);
    @(negedge clk);
    wr_start = 1'b0;
    check(done == 1'b1, tag, "done next cycle", done, 1);
    check(done_reject == exp_rej, tag, "reject flag", done_reject, exp_rej);
    check(done_count == 0, tag, "count", done_count, 0);
    repeat (20) @(negedge clk);
    check(log_n.size() == 0 && spi_cs_n, tag, "no bus frames", log_n.size(), 0);
    check(!busy, tag, "busy after quick request", busy, 0);
  endtask

  task automatic run_write(input int addr, input int len, input int cfg,
                           input bit stall, input bit poke, input int seed);
    int got_count = -1;
    int got_rej = -1;
    busy_cfg = cfg;
    build_exp(addr, len, seed);
    log_b.delete(); log_n.delete();
    @(negedge clk);
    wr_start = 1'b1; wr_addr = 24'(addr); wr_len = LEN_W'(len);
    @(negedge clk);
    wr_start = 1'b0;
    fork
      begin
        int idx = 0;
        int cyc = 0;
        while (idx < len) begin
          if (stall && (cyc % 3 == 1)) dat_valid = 1'b0;
          else begin dat_valid = 1'b1; dat_data = pat(seed, idx); end
          if (dat_valid && dat_ready) idx++;
          cyc++;
          @(negedge clk);
        end
        dat_valid = 1'b0;
      end
      begin
        int cyc = 0;
        while (!done) begin
          if (poke && cyc == 40) begin
            wr_start = 1'b1; wr_addr = 24'h000000; wr_len = LEN_W'(3);
          end else begin
            wr_start = 1'b0;
          end
          cyc++;
          @(negedge clk);
        end
        wr_start = 1'b0;
        got_count = int'(done_count);
        got_rej = int'(done_reject);
        @(negedge clk);
        check(done == 1'b0, "R7", "done lasts one cycle", done, 0);
      end
    join
    check(got_count == len, "R7", "done count", got_count, len);
    check(got_rej == 0, "R7", "reject on good write", got_rej, 0);
    repeat (60) @(negedge clk);
    check(!busy, "R10", "idle after write", busy, 0);
    compare_log();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    log_b.delete(); log_n.delete();
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R1", "sclk after reset", spi_sclk, 0);
    check(dat_ready == 1'b0, "R1", "ready after reset", dat_ready, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);

    run_write(32'h000010, 5, 0, 1'b0, 1'b0, 1);     // R4 single chunk, no busy
    run_write(32'h0000F0, 16, 1, 1'b0, 1'b0, 2);    // R4 exactly fills page
    run_write(32'h0000F0, 17, 0, 1'b1, 1'b0, 3);    // R4 one byte over
    run_write(32'h0001FF, 600, 2, 1'b1, 1'b1, 4);   // R4 R6 R10 multi-page, busy polls
    run_write(32'h000300, 256, 1, 1'b0, 1'b0, 5);   // R4 aligned full page
    quick_req(32'h000040, 0, 1'b0, "R2");           // R2 zero length
    quick_req(DEV - 10, 11, 1'b1, "R3");            // R3 overruns by one
    run_write(DEV - 10, 10, 0, 1'b0, 1'b0, 6);      // R3 ends exactly at limit

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule